// File: doc/BRIEF.md
# Card-Side Session Controller with CRC-Checked Byte Store

This block is the protocol sequencer of a contactless card emulator. It sits between a frame receiver (which delivers decoded reader frames with their bit length) and a frame transmitter (which sends reply frames and a delayed single-bit acknowledge). It also drives the control pulses of an external keystream generator.

While idle, the controller waits for the reader field. When the field appears it opens a three-step setup exchange:

1. It receives a 7-bit seed frame.
2. It answers with a 6-bit code that identifies the card type.
3. It checks the reader's 6-bit confirmation.

Once the session is up, every received frame is classified by its bit length alone. A frame as long as the card's command is a read. A frame twelve bits longer is a write. Reads return the stored byte together with a 4-bit CRC. Writes carry a CRC of their own, which the controller checks before the byte is stored and acknowledged. Any other length, any receive error and any CRC mismatch close the session.

The card geometry is selected by a 2-bit type input. The storage is one 1024-byte synchronous RAM, shared by all three card geometries. Its contents are not initialised by the block.

States and transitions:

- `ST_IDLE`
  - goes to `ST_WAIT_IV` when the field is present and the type is valid.
- `ST_WAIT_IV`
  - goes to `ST_WAIT_ACK` on a clean 7-bit frame.
  - goes to `ST_IDLE` on any other frame.
- `ST_WAIT_ACK`
  - goes to `ST_LINKED` on the correct confirmation.
  - goes to `ST_IDLE` otherwise.
- `ST_LINKED`
  - goes to `ST_RD_FETCH` on a read frame.
  - goes to `ST_CRC_RUN` on a write frame.
  - goes to `ST_IDLE` on an error or an unknown length.
- `ST_RD_FETCH`
  - always goes to `ST_CRC_RUN`.
- `ST_CRC_RUN`
  - goes to `ST_LINKED` after a read reply or an accepted write.
  - goes to `ST_IDLE` after a rejected write.

Top module: `card_session_ctrl`

## Requirements
- R1: The card type sets the command length and address width: type 0 uses 6 and 5, type 1 uses 9 and 8, type 2 uses 11 and 10. Type 3 is rejected: with the field present, no session starts and `ks_reset` never pulses.
- R2: In idle with the field present and a valid type, the block pulses `ks_reset` once and then waits for the seed frame.
- R3: A clean frame of exactly 7 bits while waiting for the seed pulses `ks_seed_load`, with `ks_seed` equal to frame bits 6:0. A frame of any other length, or one flagged as an error, returns to idle without loading a seed and without sending a reply.
- R4: In the same cycle as the seed load, the block starts a 6-bit reply (`tx_len`=6). The reply is 0x0D for type 0, 0x1D for type 1 and 0x3D for type 2.
- R5: The confirmation frame must be 6 bits long and equal 0x19 for type 0, or 0x39 for types 1 and 2. If it does, `slot_adv` pulses once and `in_session` rises. Otherwise the block returns to idle.
- R6: In session, a frame whose length equals the command length is a read. The address is frame bits shifted right by one. The reply has `tx_len`=12, with the stored byte in bits 7:0 and the CRC in bits 11:8.
- R7: The CRC is 4 bits wide, reflected, with polynomial value 0xC and start value 0x5, and no final inversion. For each bit, least significant first, the register shifts right and is XORed with 0xC when its old bit 0 differed from the input bit. It runs over the word (byte << command length) | command, which is 8 + command length bits long.
- R8: A frame of command length + 12 bits is a write. The address is bits [address width:1], the byte sits at bit offset command length, and the CRC at offset command length + 8. The CRC is checked over the address shifted left by one, with bit 0 zero. On a match, the byte is stored and `tx_ack` pulses once.
- R9: A write whose CRC does not match stores nothing, sends no acknowledge and ends the session.
- R10: In session, a frame flagged as a receive error, or of any length other than the two command lengths, ends the session (`in_session` falls) and produces no reply.
- R11: Every address within the address width is served, including those beyond the nominal card size. For example, type 0 address 31 stores and reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_type | input | 2 | Card geometry selector, sampled when a session opens |
| carrier | input | 1 | Reader field present |
| rx_valid | input | 1 | One-cycle strobe: a received frame is available |
| rx_err | input | 1 | Qualifies `rx_valid`: the frame ended in a receive error |
| rx_frame | input | 23 | Received frame bits, first bit at bit 0 |
| rx_len | input | 5 | Number of received bits |
| ks_reset | output | 1 | Pulse: clear the keystream state |
| ks_seed_load | output | 1 | Pulse: seed the keystream from `ks_seed` |
| ks_seed | output | 7 | Seed value |
| tx_start | output | 1 | Pulse: transmit `tx_frame` |
| tx_frame | output | 12 | Reply bits, first bit at bit 0 |
| tx_len | output | 5 | Reply length in bits |
| tx_ack | output | 1 | Pulse: send the delayed write acknowledge |
| slot_adv | output | 1 | Pulse: advance the frame-end timestamp by one bit slot |
| in_session | output | 1 | Setup complete and the session is still open |

## Verification
The bench builds the block with its default parameters: a 10-bit RAM address, 8-bit data and a 4-bit CRC. With these values all three card geometries are reachable, and so is the 19-bit CRC word of the largest type. The topmost address of each geometry is reachable as well, including the type-0 addresses beyond its 22 nominal bytes. Because the RAM is shared, bytes written in one session persist across reconnects, which lets the bench show that a rejected write left the old byte in place.

// File: rtl/cardctl_pkg.sv
package cardctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_IV,
        ST_WAIT_ACK,
        ST_LINKED,
        ST_RD_FETCH,
        ST_CRC_RUN
    } ctl_state_t;

    // command length in bits for each geometry, 0 when unsupported
    function automatic logic [4:0] cmd_bits(input logic [1:0] t);
        unique case (t)
            2'd0:    return 5'd6;
            2'd1:    return 5'd9;
            2'd2:    return 5'd11;
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic [5:0] type_code(input logic [1:0] t);
        unique case (t)
            2'd0:    return 6'h0D;
            2'd1:    return 6'h1D;
            default: return 6'h3D;
        endcase
    endfunction

    function automatic logic [5:0] confirm_code(input logic [1:0] t);
        return (t == 2'd0) ? 6'h19 : 6'h39;
    endfunction

endpackage

// File: rtl/cardctl_ram.sv
module cardctl_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/cardctl_crc.sv
module cardctl_crc #(
    parameter int              CRC_W  = 4,
    parameter int              WORD_W = 19,
    parameter int              CNT_W  = 5,
    parameter logic [CRC_W-1:0] POLY  = 4'hC,
    parameter logic [CRC_W-1:0] INIT  = 4'h5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  nbits,
    output logic              busy,
    output logic              done,
    output logic [CRC_W-1:0]  crc
);
    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  left;
    logic              fb;

    assign fb = crc[0] ^ sr[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            left <= '0;
            busy <= 1'b0;
            done <= 1'b0;
            crc  <= INIT;
        end else begin
            done <= 1'b0;
            if (start) begin
                sr   <= word;
                left <= nbits;
                busy <= 1'b1;
                crc  <= INIT;
            end else if (busy) begin
                sr   <= sr >> 1;
                left <= left - 1'b1;
                crc  <= (crc >> 1) ^ (fb ? POLY : '0);
                if (left == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R7
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7
    start_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/card_session_ctrl.sv
module card_session_ctrl
    import cardctl_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 8,
    parameter int CRC_W   = 4,
    parameter int FRAME_W = 23,
    parameter int LEN_W   = 5,
    parameter int TX_W    = 12,
    parameter int SEED_W  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         card_type,
    input  logic               carrier,
    input  logic               rx_valid,
    input  logic               rx_err,
    input  logic [FRAME_W-1:0] rx_frame,
    input  logic [LEN_W-1:0]   rx_len,
    output logic               ks_reset,
    output logic               ks_seed_load,
    output logic [SEED_W-1:0]  ks_seed,
    output logic               tx_start,
    output logic [TX_W-1:0]    tx_frame,
    output logic [LEN_W-1:0]   tx_len,
    output logic               tx_ack,
    output logic               slot_adv,
    output logic               in_session
);
    localparam int WORD_W = DATA_W + ADDR_W + 1;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int CODE_W = 6;

    ctl_state_t state, nxt;

    logic [1:0]        type_q;
    logic [4:0]        cmd_len;
    logic [ADDR_W-1:0] amask;
    logic              rx_ok, is_read, is_write, confirm_ok;
    logic [ADDR_W-1:0] rd_addr, wr_addr, addr_q;
    logic [DATA_W-1:0] wr_byte, byte_q, ram_rdata;
    logic [CRC_W-1:0]  wr_crc, crc_rx_q, crc_val;
    logic [ADDR_W:0]   cmd_q;
    logic              op_write_q;
    logic              crc_start, crc_busy, crc_done;
    logic [WORD_W-1:0] crc_word;
    logic              ram_we, ram_re, crc_match;

    // geometry of the latched card type
    assign cmd_len  = cmd_bits(type_q);
    assign amask    = ADDR_W'((1 << (cmd_len - 5'd1)) - 1);
    assign rx_ok    = rx_valid && !rx_err;
    assign is_read  = rx_len == LEN_W'(cmd_len);
    assign is_write = rx_len == LEN_W'(cmd_len) + LEN_W'(DATA_W + CRC_W);
    assign confirm_ok = (rx_len == LEN_W'(CODE_W)) &&
                        (rx_frame == FRAME_W'(confirm_code(type_q)));

    // field extraction from a received command
    assign rd_addr = ADDR_W'(rx_frame >> 1) & amask;
    assign wr_addr = rd_addr;
    assign wr_byte = DATA_W'(rx_frame >> cmd_len);
    assign wr_crc  = CRC_W'(rx_frame >> (cmd_len + 5'(DATA_W)));

    assign crc_match = crc_val == crc_rx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:
                if (carrier && cmd_bits(card_type) != 5'd0) nxt = ST_WAIT_IV;
            ST_WAIT_IV:
                if (rx_valid) nxt = (rx_ok && rx_len == LEN_W'(SEED_W)) ? ST_WAIT_ACK : ST_IDLE;
            ST_WAIT_ACK:
                if (rx_valid) nxt = (rx_ok && confirm_ok) ? ST_LINKED : ST_IDLE;
            ST_LINKED:
                if (rx_valid) begin
                    if (!rx_ok)        nxt = ST_IDLE;
                    else if (is_read)  nxt = ST_RD_FETCH;
                    else if (is_write) nxt = ST_CRC_RUN;
                    else               nxt = ST_IDLE;
                end
            ST_RD_FETCH:
                nxt = ST_CRC_RUN;
            ST_CRC_RUN:
                if (crc_done) nxt = (!op_write_q || crc_match) ? ST_LINKED : ST_IDLE;
            default:
                nxt = ST_IDLE;
        endcase
    end

    // command latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q     <= 2'd0;
            addr_q     <= '0;
            byte_q     <= '0;
            crc_rx_q   <= '0;
            cmd_q      <= '0;
            op_write_q <= 1'b0;
        end else begin
            if (state == ST_IDLE) type_q <= card_type;
            if (state == ST_LINKED && rx_ok) begin
                op_write_q <= is_write;
                cmd_q      <= rx_frame[ADDR_W:0];
                addr_q     <= wr_addr;
                byte_q     <= wr_byte;
                crc_rx_q   <= wr_crc;
            end
            if (state == ST_RD_FETCH) byte_q <= ram_rdata;
        end
    end

    // outputs and datapath strobes
    always_comb begin
        ks_reset     = 1'b0;
        ks_seed_load = 1'b0;
        ks_seed      = rx_frame[SEED_W-1:0];
        tx_start     = 1'b0;
        tx_frame     = '0;
        tx_len       = '0;
        tx_ack       = 1'b0;
        slot_adv     = 1'b0;
        ram_re       = 1'b0;
        ram_we       = 1'b0;
        crc_start    = 1'b0;
        crc_word     = (WORD_W'(wr_byte) << cmd_len) | WORD_W'({wr_addr, 1'b0});
        in_session   = 1'b0;
        unique case (state)
            ST_IDLE:
                ks_reset = nxt == ST_WAIT_IV;
            ST_WAIT_IV:
                if (nxt == ST_WAIT_ACK) begin
                    ks_seed_load = 1'b1;
                    tx_start     = 1'b1;
                    tx_frame     = TX_W'(type_code(type_q));
                    tx_len       = LEN_W'(CODE_W);
                end
            ST_WAIT_ACK:
                slot_adv = nxt == ST_LINKED;
            ST_LINKED: begin
                in_session = 1'b1;
                ram_re     = nxt == ST_RD_FETCH;
                crc_start  = nxt == ST_CRC_RUN;
            end
            ST_RD_FETCH: begin
                in_session = 1'b1;
                crc_start  = 1'b1;
                crc_word   = (WORD_W'(ram_rdata) << cmd_len) | WORD_W'(cmd_q);
            end
            ST_CRC_RUN: begin
                in_session = 1'b1;
                if (crc_done && !op_write_q) begin
                    tx_start = 1'b1;
                    tx_frame = TX_W'({crc_val, byte_q});
                    tx_len   = LEN_W'(DATA_W + CRC_W);
                end
                if (crc_done && op_write_q && crc_match) begin
                    ram_we = 1'b1;
                    tx_ack = 1'b1;
                end
            end
            default: ;
        endcase
    end

    cardctl_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (addr_q),
        .wdata (byte_q),
        .re    (ram_re),
        .raddr (rd_addr),
        .rdata (ram_rdata)
    );

    cardctl_crc #(.CRC_W(CRC_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (crc_start),
        .word  (crc_word),
        .nbits (CNT_W'(cmd_len) + CNT_W'(DATA_W)),
        .busy  (crc_busy),
        .done  (crc_done),
        .crc   (crc_val)
    );

    // R4 R6
    tx_len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (tx_len == LEN_W'(CODE_W) || tx_len == LEN_W'(DATA_W + CRC_W)));
    // R2 R3 R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ks_reset, ks_seed_load, tx_ack, slot_adv}));
    // R5
    session_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_session) |-> $past(slot_adv));
    // R10
    err_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LINKED && rx_valid && rx_err) |=> !in_session);
    // R8 R9
    ack_in_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |-> in_session && !crc_busy);
endmodule

// File: tb/test_card_session_ctrl.sv
`timescale 1ns/1ps
module test_card_session_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  card_type = 2'd0;
    logic        carrier = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_err = 1'b0;
    logic [22:0] rx_frame = '0;
    logic [4:0]  rx_len = '0;
    logic        ks_reset, ks_seed_load, tx_start, tx_ack, slot_adv, in_session;
    logic [6:0]  ks_seed;
    logic [11:0] tx_frame;
    logic [4:0]  tx_len;

    always #4 clk = ~clk;

    card_session_ctrl i_card_session_ctrl (
        .clk(clk), .rst_n(rst_n), .card_type(card_type), .carrier(carrier),
        .rx_valid(rx_valid), .rx_err(rx_err), .rx_frame(rx_frame), .rx_len(rx_len),
        .ks_reset(ks_reset), .ks_seed_load(ks_seed_load), .ks_seed(ks_seed),
        .tx_start(tx_start), .tx_frame(tx_frame), .tx_len(tx_len), .tx_ack(tx_ack),
        .slot_adv(slot_adv), .in_session(in_session)
    );

    int n_run = 0, n_fail = 0;
    int n_tx = 0, n_ack = 0, n_seed = 0, n_ksr = 0, n_slot = 0;
    logic [11:0] last_tx;
    logic [4:0]  last_len;
    logic [6:0]  last_seed;
    logic [7:0]  model [1024];
    bit          known [1024];

    always @(negedge clk) if (rst_n) begin
        if (tx_start)     begin n_tx++; last_tx = tx_frame; last_len = tx_len; end
        if (tx_ack)       n_ack++;
        if (ks_seed_load) begin n_seed++; last_seed = ks_seed; end
        if (ks_reset)     n_ksr++;
        if (slot_adv)     n_slot++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int f_cmd(input int t);
        return (t == 0) ? 6 : (t == 1) ? 9 : 11;
    endfunction

    // R7 reference
    function automatic logic [3:0] f_crc(input logic [18:0] w, input int n);
        logic [3:0] c = 4'h5;
        for (int i = 0; i < n; i++) begin
            logic x = c[0] ^ w[i];
            c = c >> 1;
            if (x) c = c ^ 4'hC;
        end
        return c;
    endfunction

    task automatic send(input logic [22:0] f, input int len, input bit err);
        @(posedge clk); #1;
        rx_frame = f; rx_len = 5'(len); rx_valid = 1'b1; rx_err = err;
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_err = 1'b0;
        repeat (30) @(posedge clk);
        #1;
    endtask

    task automatic drop;
        carrier = 1'b0;
        send(23'h0, 1, 1'b1);
    endtask

    task automatic connect(input int t);
        int k, s, x, sl;
        logic [6:0] iv;
        drop();
        card_type = 2'(t);
        k = n_ksr;
        carrier = 1'b1;
        repeat (3) @(posedge clk); #1;
        chk(n_ksr == k + 1, "R2 ks_reset on field", n_ksr - k, 1);
        iv = 7'($urandom_range(0, 127));
        s = n_seed; x = n_tx;
        send(23'(iv), 7, 1'b0);
        chk(n_seed == s + 1 && last_seed == iv, "R3 seed load", last_seed, iv);
        chk(n_tx == x + 1 && last_len == 6 &&
            last_tx == ((t == 0) ? 12'h0D : (t == 1) ? 12'h1D : 12'h3D),
            "R4 type reply", last_tx, t);
        sl = n_slot;
        send((t == 0) ? 23'h19 : 23'h39, 6, 1'b0);
        chk(in_session && n_slot == sl + 1, "R5 confirm accepted", n_slot - sl, 1);
    endtask

    task automatic do_write(input int t, input int a, input logic [7:0] b, input bit bad);
        int c = f_cmd(t);
        int k = n_ack;
        logic [18:0] w = (19'(b) << c) | 19'(a << 1);
        logic [3:0]  cr = f_crc(w, c + 8);
        if (bad) cr = cr ^ 4'h1;
        send(23'(w) | (23'(cr) << (c + 8)), c + 12, 1'b0);
        if (!bad) begin
            chk(n_ack == k + 1 && in_session, "R8 write acked", n_ack - k, 1);
            model[a] = b; known[a] = 1'b1;
        end else begin
            chk(n_ack == k && !in_session, "R9 bad crc rejected", n_ack - k, 0);
        end
    endtask

    task automatic do_read(input int t, input int a, input string req);
        int c = f_cmd(t);
        int x = n_tx;
        logic [18:0] cmdw = 19'((a << 1) | 1);
        logic [3:0]  cr = f_crc((19'(model[a]) << c) | cmdw, c + 8);
        send(23'(cmdw), c, 1'b0);
        chk(n_tx == x + 1 && last_len == 12 && last_tx == {cr, model[a]},
            req, last_tx, {cr, model[a]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int base, k, s, x, a;
        int addrs [8];
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!in_session && !tx_start && !tx_ack && !ks_reset, "R2 reset state", in_session, 0);

        // R1 unsupported type
        card_type = 2'd3; k = n_ksr; carrier = 1'b1;
        repeat (10) @(posedge clk); #1;
        chk(n_ksr == k && !in_session, "R1 type 3 rejected", n_ksr - k, 0);
        carrier = 1'b0;

        // R3 wrong seed length
        card_type = 2'd1; carrier = 1'b1;
        repeat (3) @(posedge clk); #1;
        s = n_seed; x = n_tx;
        send(23'h55, 8, 1'b0);
        chk(n_seed == s && n_tx == x, "R3 bad seed length", n_seed - s, 0);

        // R5 wrong confirmation for type 0
        drop(); card_type = 2'd0; carrier = 1'b1;
        repeat (3) @(posedge clk); #1;
        send(23'h12, 7, 1'b0);
        send(23'h39, 6, 1'b0);
        chk(!in_session, "R5 wrong confirm", in_session, 0);

        for (int t = 0; t < 3; t++) begin
            int c = f_cmd(t);
            int amax = (1 << (c - 1)) - 1;
            connect(t);
            for (int i = 0; i < 7; i++) begin
                a = (i == 0) ? amax : $urandom_range(0, amax);
                addrs[i] = a;
                do_write(t, a, 8'($urandom_range(0, 255)), 1'b0);
            end
            for (int i = 1; i < 7; i++) do_read(t, addrs[i], "R6 read reply");
            do_read(t, amax, "R11 top address");
            do_read(t, addrs[3], "R7 read crc");
            // R9 rejected write leaves old byte
            do_write(t, addrs[2], model[addrs[2]] ^ 8'hFF, 1'b1);
            connect(t);
            do_read(t, addrs[2], "R9 old byte kept");
            // R10 unknown length
            x = n_tx;
            send(23'h3, c + 1, 1'b0);
            chk(!in_session && n_tx == x, "R10 bad length", in_session, 0);
            // R10 receive error
            connect(t);
            x = n_tx;
            carrier = 1'b0;
            send(23'((addrs[1] << 1) | 1), c, 1'b1);
            chk(!in_session && n_tx == x, "R10 rx error", in_session, 0);
        end
        base = 0;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule